// File: doc/BRIEF.md
# Programmable Local Bus Strobe Timer

This block drives single read and write cycles on a simple parallel local bus as the bus master. A requester raises a start pulse with the direction, an address and write data. The block then runs a cycle counter. The counter reads 0 on the reference cycle, which is the first clock after the request is taken. Every strobe edge sits at a clock count held in a 32-bit timing register, so slow and fast peripherals can share one bus with no change to the logic.

The same timing fields serve two signalling styles. In the first style, a read uses its own read strobe and a write uses its own write strobe. In the second style, both directions use a pair of data strobes, and a read-not-write line gives the direction. Each strobe edge is placed on its own by its own field. The timing register and the mode are captured when the request is taken, so a change made during a cycle affects only later cycles.

Top module: `lb_strobe_timer`

## Requirements
- R1: The strobe is low from the counter value in its assert field until just before the counter value in its release field. The counter is 0 on the reference cycle. A write uses assert bits 27:24 and release bits 31:28. A read uses assert bits 19:16 and release bits 23:20.
- R2: A field code above 10 acts as 10.
- R3: If a release code is not greater than its assert code, after R2 clamping, the strobe is low for exactly one clock, at the assert count.
- R4: With `mode_moto`=0, a read drives `bus_rd_n` and a write drives `bus_wr_n`. Both `bus_ds_n` bits stay 1 and `bus_rnw` stays 1.
- R5: With `mode_moto`=1, both `bus_ds_n` bits act as the strobe for either direction, and `bus_rd_n` and `bus_wr_n` stay 1. On a write, `bus_rnw` is 0 from the reference cycle until the chip-select release count of R6. On a read, `bus_rnw` stays 1.
- R6: Only `bus_cs_n[i]` goes low, where i is the top address bit(s) of the request. It is low from the reference cycle until the release count, with a minimum of one clock. On a write, the release count is bits 15:12, clamped as in R2. On a read, it is the `RD_CS_OFF` parameter. All other chip selects stay 1.
- R7: On a read, `rd_data` takes the `bus_din` value that is present in the last clock of the strobe-low window. A write leaves `rd_data` unchanged.
- R8: `done` is high for one clock, at counter value L+1. L is the larger of the strobe release count and the chip-select release count. In that clock, every strobe and chip select is 1.
- R9: A request is taken only while `busy` is 0. A request raised while a cycle is running, or in its done clock, is ignored.
- R10: After reset, with `PP_PROFILE`=0, the timing register holds these values: write assert 0, write release 2, read assert 0, read release 3, write chip-select release 2. With `PP_PROFILE`=1, both assert fields are 1 and the read release is 2.
- R11: `bus_addr` and `bus_dout` hold the request's address and write data from the reference cycle onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_we | input | 1 | Timing register write enable |
| cfg_wdata | input | 32 | Timing register write value |
| req | input | 1 | Start request |
| req_wr | input | 1 | Request direction, 1 = write |
| req_addr | input | ADDR_W | Request address |
| req_wdata | input | DATA_W | Request write data |
| mode_moto | input | 1 | Signalling style, 1 = data strobes with direction line |
| bus_din | input | DATA_W | Read data from the bus |
| bus_addr | output | ADDR_W | Bus address |
| bus_dout | output | DATA_W | Bus write data |
| bus_cs_n | output | NUM_CS | Active-low chip selects |
| bus_rd_n | output | 1 | Active-low read strobe |
| bus_wr_n | output | 1 | Active-low write strobe |
| bus_ds_n | output | 2 | Active-low data strobes |
| bus_rnw | output | 1 | Read-not-write line |
| rd_data | output | DATA_W | Captured read data |
| done | output | 1 | End-of-cycle pulse |
| busy | output | 1 | Cycle in progress |

## Verification
The bench sweeps every assert and release code, 0 to 15, in both styles and both directions. This covers the reserved codes that must clamp to 10, and the release-before-assert pairs that must still give one low clock. A design that skipped the clamp would stretch strobes past count 10. A design that got the one-clock rule wrong would give a strobe that never goes low. The bench changes `bus_din` every clock, so a capture one clock early or late returns a different value. It also raises requests while a cycle runs and in its done clock; a design that accepted them would start a second cycle or move the address.

// File: rtl/lbst_pkg.sv
package lbst_pkg;
   localparam int unsigned CODE_W   = 4;
   localparam int unsigned CODE_MAX = 10;
   localparam int unsigned TIM_W    = 32;
   // field positions inside the timing word
   localparam int unsigned F_WCS_OFF = 12;
   localparam int unsigned F_RD_ON   = 16;
   localparam int unsigned F_RD_OFF  = 20;
   localparam int unsigned F_WR_ON   = 24;
   localparam int unsigned F_WR_OFF  = 28;

   typedef logic [CODE_W-1:0] code_t;
   typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_FIN} seq_st_e;

   function automatic code_t clamp_code(input code_t c);
      return (c > code_t'(CODE_MAX)) ? code_t'(CODE_MAX) : c;
   endfunction
endpackage

// File: rtl/lbst_cfg_reg.sv
module lbst_cfg_reg #(
   parameter bit PP_PROFILE = 1'b0
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     we,
   input  logic [lbst_pkg::TIM_W-1:0] wdata,
   output logic [lbst_pkg::TIM_W-1:0] tim
);
   logic [lbst_pkg::TIM_W-1:0] rst_val;

   generate
      if (PP_PROFILE) begin : g_pp
         assign rst_val = {4'h2, 4'h1, 4'h2, 4'h1, 4'h2, 12'h000};
      end else begin : g_std
         assign rst_val = {4'h2, 4'h0, 4'h3, 4'h0, 4'h2, 12'h000};
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  tim <= rst_val;
      else if (we) tim <= wdata;
   end
endmodule

// File: rtl/lbst_edge_gen.sv
module lbst_edge_gen #(
   parameter int unsigned CNT_W = 4
) (
   input  logic                  run,
   input  logic [CNT_W-1:0]      cnt,
   input  lbst_pkg::code_t       on_code,
   input  lbst_pkg::code_t       off_code,
   output logic                  low_o,
   output logic [CNT_W-1:0]      off_eff_o
);
   import lbst_pkg::*;

   code_t            on_c, off_c;
   logic [CNT_W-1:0] on_w;

   generate
      if (CNT_W < CODE_W + 0) begin : g_bad_w
         $error("lbst_edge_gen: CNT_W too narrow");
      end
   endgenerate

   always_comb begin
      on_c      = clamp_code(on_code);
      off_c     = clamp_code(off_code);
      on_w      = CNT_W'(on_c);
      off_eff_o = (off_c > on_c) ? CNT_W'(off_c) : on_w + CNT_W'(1);
      low_o     = run && (cnt >= on_w) && (cnt < off_eff_o);
   end

   always_comb begin
      if (run) a_r2_release_clamped: assert (off_eff_o <= CNT_W'(CODE_MAX + 1));
   end
endmodule

// File: rtl/lbst_seq.sv
module lbst_seq #(
   parameter int unsigned CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req,
   input  logic [CNT_W-1:0] last,
   output logic             accept,
   output logic             run,
   output logic             done,
   output logic             busy,
   output logic [CNT_W-1:0] cnt
);
   import lbst_pkg::*;

   seq_st_e st;

   assign accept = (st == ST_IDLE) && req;
   assign run    = (st == ST_RUN);
   assign done   = (st == ST_FIN);
   assign busy   = (st != ST_IDLE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st  <= ST_IDLE;
         cnt <= '0;
      end else begin
         case (st)
            ST_IDLE: if (req) begin
               st  <= ST_RUN;
               cnt <= '0;
            end
            ST_RUN: if (cnt == last) st <= ST_FIN;
                    else             cnt <= cnt + CNT_W'(1);
            default: st <= ST_IDLE;
         endcase
      end
   end

   a_r8_fin_one_clock: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> (st == ST_IDLE));
   a_r1_count_from_zero: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> (run && cnt == '0));
endmodule

// File: rtl/lb_strobe_timer.sv
module lb_strobe_timer #(
   parameter int unsigned ADDR_W     = 8,
   parameter int unsigned DATA_W     = 8,
   parameter int unsigned NUM_CS     = 2,
   parameter int unsigned RD_CS_OFF  = 4,
   parameter bit          PP_PROFILE = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [31:0]       cfg_wdata,
   input  logic              req,
   input  logic              req_wr,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   input  logic              mode_moto,
   input  logic [DATA_W-1:0] bus_din,
   output logic [ADDR_W-1:0] bus_addr,
   output logic [DATA_W-1:0] bus_dout,
   output logic [NUM_CS-1:0] bus_cs_n,
   output logic              bus_rd_n,
   output logic              bus_wr_n,
   output logic [1:0]        bus_ds_n,
   output logic              bus_rnw,
   output logic [DATA_W-1:0] rd_data,
   output logic              done,
   output logic              busy
);
   import lbst_pkg::*;

   localparam int unsigned CNT_W    = $clog2(CODE_MAX + 3);
   localparam int unsigned CS_SEL_W = (NUM_CS > 1) ? $clog2(NUM_CS) : 1;
   localparam int unsigned N_WIN    = 2;   // 0: strobe, 1: select/direction

   generate
      if (NUM_CS < 2 || (NUM_CS & (NUM_CS - 1)) != 0) begin : g_bad_cs
         $error("lb_strobe_timer: NUM_CS must be a power of two >= 2");
      end
      if (RD_CS_OFF < 1 || RD_CS_OFF > CODE_MAX) begin : g_bad_rdcs
         $error("lb_strobe_timer: RD_CS_OFF out of range");
      end
      if (ADDR_W < CS_SEL_W) begin : g_bad_aw
         $error("lb_strobe_timer: ADDR_W too narrow");
      end
   endgenerate

   logic [TIM_W-1:0]    tim, tim_q;
   logic                wr_q, moto_q;
   logic [CS_SEL_W-1:0] sel_q;
   logic                accept, run;
   logic [CNT_W-1:0]    cnt, last;
   code_t               on_code  [N_WIN];
   code_t               off_code [N_WIN];
   logic                win_low  [N_WIN];
   logic [CNT_W-1:0]    off_eff  [N_WIN];

   lbst_cfg_reg #(.PP_PROFILE(PP_PROFILE)) cfg_i (
      .clk(clk), .rst_n(rst_n), .we(cfg_we), .wdata(cfg_wdata), .tim(tim));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tim_q    <= '0;
         wr_q     <= 1'b0;
         moto_q   <= 1'b0;
         sel_q    <= '0;
         bus_addr <= '0;
         bus_dout <= '0;
      end else if (accept) begin
         tim_q    <= tim;
         wr_q     <= req_wr;
         moto_q   <= mode_moto;
         sel_q    <= req_addr[ADDR_W-1 -: CS_SEL_W];
         bus_addr <= req_addr;
         bus_dout <= req_wdata;
      end
   end

   always_comb begin
      on_code[0]  = wr_q ? tim_q[F_WR_ON +: CODE_W]  : tim_q[F_RD_ON +: CODE_W];
      off_code[0] = wr_q ? tim_q[F_WR_OFF +: CODE_W] : tim_q[F_RD_OFF +: CODE_W];
      on_code[1]  = '0;
      off_code[1] = wr_q ? tim_q[F_WCS_OFF +: CODE_W] : code_t'(RD_CS_OFF);
   end

   generate
      for (genvar w = 0; w < N_WIN; w++) begin : g_win
         lbst_edge_gen #(.CNT_W(CNT_W)) edge_i (
            .run(run), .cnt(cnt), .on_code(on_code[w]), .off_code(off_code[w]),
            .low_o(win_low[w]), .off_eff_o(off_eff[w]));
      end
   endgenerate

   assign last = (off_eff[0] > off_eff[1]) ? off_eff[0] : off_eff[1];

   lbst_seq #(.CNT_W(CNT_W)) seq_i (
      .clk(clk), .rst_n(rst_n), .req(req), .last(last),
      .accept(accept), .run(run), .done(done), .busy(busy), .cnt(cnt));

   assign bus_rd_n = !(!moto_q && !wr_q && win_low[0]);
   assign bus_wr_n = !(!moto_q &&  wr_q && win_low[0]);
   assign bus_ds_n = (moto_q && win_low[0]) ? 2'b00 : 2'b11;
   assign bus_rnw  = !(moto_q && wr_q && win_low[1]);

   generate
      for (genvar c = 0; c < NUM_CS; c++) begin : g_cs
         assign bus_cs_n[c] = !(win_low[1] && (sel_q == CS_SEL_W'(c)));
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rd_data <= '0;
      else if (run && !wr_q && (cnt == off_eff[0] - CNT_W'(1))) rd_data <= bus_din;
   end

   a_r6_single_select: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(~bus_cs_n));
   a_r6_select_at_ref: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> !(&bus_cs_n));
   a_r4_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(!bus_rd_n && !bus_wr_n));
   a_r5_ds_excludes_rdwr: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_ds_n[0] |-> (bus_rd_n && bus_wr_n));
   a_r8_done_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> ((&bus_cs_n) && bus_rd_n && bus_wr_n && (&bus_ds_n) && bus_rnw));
   a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   a_r9_busy_holds_addr: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> $stable(bus_addr));
endmodule

// File: tb/lb_strobe_timer_tb_top.sv
`timescale 1ns/1ps
module lb_strobe_timer_tb_top;
   localparam int AW = 8, DW = 8, RDCS = 4;
   localparam realtime TCK = 8.0;

   logic clk = 1'b0, rst_n = 1'b0;
   logic cfg_we = 1'b0;
   logic [31:0] cfg_wdata = '0;
   logic req = 1'b0, req_wr = 1'b0, mode_moto = 1'b0;
   logic [AW-1:0] req_addr = '0;
   logic [DW-1:0] req_wdata = '0, bus_din = '0;
   logic [AW-1:0] bus_addr;
   logic [DW-1:0] bus_dout, rd_data;
   logic [1:0] bus_cs_n, bus_ds_n;
   logic bus_rd_n, bus_wr_n, bus_rnw, done, busy;

   int total = 0, bad = 0;
   bit finished = 1'b0;
   int exp_rd = 0;

   always #(TCK/2) clk = ~clk;

   lb_strobe_timer #(.ADDR_W(AW), .DATA_W(DW), .NUM_CS(2), .RD_CS_OFF(RDCS),
                     .PP_PROFILE(1'b0)) dut_i (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
      .req(req), .req_wr(req_wr), .req_addr(req_addr), .req_wdata(req_wdata),
      .mode_moto(mode_moto), .bus_din(bus_din), .bus_addr(bus_addr),
      .bus_dout(bus_dout), .bus_cs_n(bus_cs_n), .bus_rd_n(bus_rd_n),
      .bus_wr_n(bus_wr_n), .bus_ds_n(bus_ds_n), .bus_rnw(bus_rnw),
      .rd_data(rd_data), .done(done), .busy(busy));

   task automatic chk(input string tag, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s at %0t: actual=%0h expected=%0h", tag, $time, act, exp);
      end
   endtask

   function automatic int clampc(input int c);
      return (c > 10) ? 10 : c;
   endfunction

   task automatic cfg_write(input logic [31:0] v);
      @(negedge clk); cfg_we = 1'b1; cfg_wdata = v;
      @(negedge clk); cfg_we = 1'b0;
   endtask

   // a/d: strobe codes of the chosen direction; wcs: write select code
   task automatic run_tx(input bit wr, input bit moto, input logic [AW-1:0] addr,
                         input logic [DW-1:0] wd, input int a, input int d,
                         input int wcs, input bit inject, input string stag);
      int aa, dd, de, cse, last, sel;
      bit sl, rl;
      aa  = clampc(a);
      dd  = clampc(d);
      de  = (dd > aa) ? dd : aa + 1;
      cse = wr ? ((clampc(wcs) == 0) ? 1 : clampc(wcs)) : RDCS;
      last = (de > cse) ? de : cse;
      sel = int'(addr[AW-1]);
      @(negedge clk);
      req = 1'b1; req_wr = wr; mode_moto = moto; req_addr = addr; req_wdata = wd;
      @(negedge clk);
      for (int k = 0; k <= last + 1; k++) begin
         if (k > 0) @(negedge clk);
         sl = (k >= aa) && (k < de);
         rl = (k < cse);
         chk(stag, int'(bus_rd_n), int'(!(!moto && !wr && sl)));
         chk(stag, int'(bus_wr_n), int'(!(!moto && wr && sl)));
         chk(moto ? "R5" : "R4", int'(bus_ds_n), (moto && sl) ? 0 : 3);
         chk(moto ? "R5" : "R4", int'(bus_rnw), int'(!(moto && wr && rl)));
         chk("R6", int'(bus_cs_n), rl ? (sel ? 1 : 2) : 3);
         chk("R8", int'(done), int'(k == last + 1));
         chk("R9", int'(busy), 1);
         if (k == 0) begin
            chk("R11", int'(bus_addr), int'(addr));
            chk("R11", int'(bus_dout), int'(wd));
         end
         if (k == last + 1) begin
            if (!wr) exp_rd = (8'hA0 + de - 1) & 8'hFF;
            chk("R7", int'(rd_data), exp_rd);
         end
         if (inject && (k == 1 || k == last + 1)) begin
            req = 1'b1; req_addr = ~addr; req_wdata = ~wd;
         end else begin
            req = 1'b0;
         end
         bus_din = DW'(8'hA0 + k);
      end
      @(negedge clk);
      req = 1'b0;
      chk("R9", int'(busy), 0);
      chk("R9", int'(bus_cs_n), 3);
      chk("R9", int'(bus_addr), int'(addr));
   endtask

   initial begin
      #(TCK * 190000);
      if (!finished) begin
         total++; bad++;
         $display("FAIL watchdog expired");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // reset state of outputs
      chk("R10", int'(busy), 0);
      chk("R10", int'(bus_cs_n), 3);
      chk("R10", int'({bus_rd_n, bus_wr_n, bus_ds_n, bus_rnw}), 5'h1F);
      chk("R10", int'(rd_data), 0);
      rst_n = 1'b1;
      // R10: reset timing values (write 0/2 cs 2, read 0/3)
      run_tx(1'b1, 1'b0, 8'h80, 8'h5A, 0, 2, 2, 1'b0, "R10");
      run_tx(1'b0, 1'b0, 8'h01, 8'h00, 0, 3, 2, 1'b0, "R10");
      run_tx(1'b0, 1'b1, 8'h81, 8'h00, 0, 3, 2, 1'b0, "R10");
      // full sweep over codes, directions and styles (R1, R2, R3)
      for (int m = 0; m < 2; m++)
         for (int w = 0; w < 2; w++)
            for (int a = 0; a < 16; a++)
               for (int d = 0; d < 16; d++) begin
                  logic [3:0] a4, d4, c4;
                  string tg;
                  a4 = 4'(a); d4 = 4'(d); c4 = 4'(a + d);
                  tg = (a > 10 || d > 10) ? "R2" :
                       ((clampc(d) <= clampc(a)) ? "R3" : "R1");
                  cfg_write({d4, a4, d4, a4, c4, 12'h000});
                  run_tx(w[0], m[0], {a4[0] ^ d4[0], 3'b010, a4}, {d4, a4},
                         a, d, int'(c4), 1'b0, tg);
               end
      // R9: requests raised while running and in the done clock
      cfg_write({4'h6, 4'h2, 4'h5, 4'h1, 4'h3, 12'h000});
      run_tx(1'b1, 1'b0, 8'h12, 8'h3C, 2, 6, 3, 1'b1, "R1");
      run_tx(1'b0, 1'b1, 8'h93, 8'h00, 1, 5, 3, 1'b1, "R1");
      run_tx(1'b1, 1'b1, 8'h04, 8'hC3, 2, 6, 3, 1'b1, "R1");
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule